// File: doc/BRIEF.md
# Bus slave access guard

This block screens every bus access aimed at six slaves: a main bus interface (slot 0), a flash interface (slot 1), an SRAM (slot 2) and three peripheral interfaces (slots 3 to 5). For each slot it holds four protect enables. They cover read and write for each of two master classes, the CPU and master group A. Each access presents its master class, its direction and its slot number. The guard grants the access or refuses it. A refused write never reaches the slave. A refused read returns zero to the master.

A refused access also raises a one-cycle violation response. A control bit selects the response: a non-maskable interrupt or a reset request. The guard is configured through a 16-bit register port. Writes to the control bits take effect only with a key byte. A lock bit freezes all per-slot registers.

Top module: `slave_access_guard`

## Requirements
- R1: After reset every register reads zero, every access is granted, and the violation response is the interrupt.
- R2: A write to offset 0x00 updates bit 0 (response select) and bit 1 (lock) only when write bits 15:8 equal 0xA5. Any other key leaves both bits unchanged.
- R3: Offset 0x00 reads back as zero in bits 15:2, so the key is never visible.
- R4: While the lock bit is 1, writes to all per-slot registers are ignored and their contents still read back. Offset 0x00 stays writable through the key.
- R5: Per-slot register bits are: bit 0 CPU read protect, bit 1 CPU write protect, bit 2 group A read protect, bit 3 group A write protect. Bits 15:4 read zero. Slot 0 implements only bits 3:2, and its bits 1:0 read zero.
- R6: The per-slot registers for slots 0 to 5 sit at offsets 0x10, 0x14, 0x18, 0x20, 0x24 and 0x28. The read data is combinational on the offset.
- R7: An access is refused (`accGrant` low) when the protect bit matching its class (`accGroupA`: 0 = CPU, 1 = group A), its direction and its slot is 1. Slot numbers 6 and 7 are never refused.
- R8: `mstRdData` is zero for a refused access and equals `slvRdData` otherwise.
- R9: One clock after a refused access is sampled, exactly one of `nmiPulse` (response select 0) or `rstReqPulse` (response select 1) is high for that cycle. The response select used is the value held at the sampling edge. No pulse follows a cycle without a refusal.
- R10: Writes to unmapped offsets change nothing, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | ADDR_W (8) | Register byte offset |
| cfgWrData | input | 16 | Register write data |
| cfgRdData | output | 16 | Register read data for `cfgAddr` |
| accValid | input | 1 | An access is presented this cycle |
| accGroupA | input | 1 | Master class: 0 CPU, 1 group A |
| accWrite | input | 1 | Direction: 1 write, 0 read |
| accSlave | input | 3 | Target slot number |
| slvRdData | input | DATA_W (32) | Read data returned by the slave |
| mstRdData | output | DATA_W (32) | Read data delivered to the master |
| accGrant | output | 1 | Access allowed |
| nmiPulse | output | 1 | Violation interrupt pulse |
| rstReqPulse | output | 1 | Violation reset request pulse |

## Verification
The hardest state to reach is a locked configuration that still changes its response mode. This needs a keyed lock, then refused slot writes, then a keyed control write that flips the response select while the lock holds, and finally a violation that shows which pulse follows. Directed sequences build that chain explicitly. Seeded random traffic with a 50% correct-key rate then locks and unlocks the guard repeatedly while accesses keep running. The random traffic also covers edges where a response-select change and a violation fall on the same edge.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int NumPeriph = 3;
  localparam int NumSlaves = 3 + NumPeriph;
  localparam int SelW      = $clog2(NumSlaves);
  localparam int RegW      = 16;
  localparam int AcrW      = 4;
  localparam int MainIdx   = 0;
  localparam logic [7:0] KeyVal  = 8'hA5;
  localparam logic [7:0] CtlOff  = 8'h00;
  localparam logic [AcrW-1:0] MainMask = 4'hC;

  // byte offset of the per-slot register for slot idx
  function automatic logic [7:0] acrOffset(input int idx);
    if (idx < 3) return 8'h10 + 8'(4 * idx);
    else         return 8'h20 + 8'(4 * (idx - 3));
  endfunction

  // implemented bits of a slot register
  function automatic logic [AcrW-1:0] acrMask(input int idx);
    return (idx == MainIdx) ? MainMask : {AcrW{1'b1}};
  endfunction

  typedef struct packed {
    logic                 ctlRd;
    logic                 ctlWr;
    logic [NumSlaves-1:0] acrRd;
    logic [NumSlaves-1:0] acrWr;
  } cfgStrobe_t;
endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [7:0]        cfgKey,
  input  logic              lockQ,
  input  logic              respSelQ,
  input  logic              accDenied,
  output cfgStrobe_t        strb,
  output logic              nmiPulse,
  output logic              rstReqPulse
);
  logic ctlHit;

  always_comb begin
    strb   = '0;
    ctlHit = (cfgAddr == ADDR_W'(CtlOff));
    strb.ctlRd = ctlHit;
    strb.ctlWr = cfgWrEn && ctlHit && (cfgKey == KeyVal);
    for (int i = 0; i < NumSlaves; i++) begin
      strb.acrRd[i] = (cfgAddr == ADDR_W'(acrOffset(i)));
      strb.acrWr[i] = cfgWrEn && strb.acrRd[i] && !lockQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPulse    <= 1'b0;
      rstReqPulse <= 1'b0;
    end else begin
      nmiPulse    <= accDenied && !respSelQ;
      rstReqPulse <= accDenied &&  respSelQ;
    end
  end

  // a wrong key leaves the control bits untouched
  assert_key_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && ctlHit && cfgKey != KeyVal) |=> $stable({lockQ, respSelQ}));

  assert_resp_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(nmiPulse && rstReqPulse));

  assert_resp_after_denial_R9: assert property (@(posedge clk) disable iff (!rstN)
    accDenied |=> (nmiPulse || rstReqPulse));
endmodule

// File: rtl/guard_dp.sv
module guard_dp
  import guard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [RegW-1:0]   cfgWrData,
  output logic [RegW-1:0]   cfgRdData,
  output logic              lockQ,
  output logic              respSelQ,
  input  logic              accValid,
  input  logic              accGroupA,
  input  logic              accWrite,
  input  logic [SelW-1:0]   accSlave,
  input  logic [DATA_W-1:0] slvRdData,
  output logic [DATA_W-1:0] mstRdData,
  output logic              accGrant,
  output logic              accDenied
);
  logic [NumSlaves-1:0][AcrW-1:0] acrQ;
  logic [1:0] bitSel;
  logic       protBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ    <= 1'b0;
      respSelQ <= 1'b0;
    end else if (strb.ctlWr) begin
      lockQ    <= cfgWrData[1];
      respSelQ <= cfgWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acrQ <= '0;
    end else begin
      for (int i = 0; i < NumSlaves; i++)
        if (strb.acrWr[i]) acrQ[i] <= cfgWrData[AcrW-1:0] & acrMask(i);
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (strb.ctlRd) cfgRdData = {{(RegW-2){1'b0}}, lockQ, respSelQ};
    for (int i = 0; i < NumSlaves; i++)
      if (strb.acrRd[i]) cfgRdData = {{(RegW-AcrW){1'b0}}, acrQ[i]};
  end

  // bit index: {class, direction}
  always_comb begin
    bitSel  = {accGroupA, accWrite};
    protBit = 1'b0;
    for (int i = 0; i < NumSlaves; i++)
      if (accSlave == SelW'(i)) protBit = acrQ[i][bitSel];
  end

  assign accDenied = accValid && protBit;
  assign accGrant  = accValid && !protBit;
  assign mstRdData = protBit ? '0 : slvRdData;

  assert_lock_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(acrQ));

  assert_main_low_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    acrQ[MainIdx][1:0] == 2'b00);
endmodule

// File: rtl/slave_access_guard.sv
module slave_access_guard
  import guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [RegW-1:0]   cfgWrData,
  output logic [RegW-1:0]   cfgRdData,
  input  logic              accValid,
  input  logic              accGroupA,
  input  logic              accWrite,
  input  logic [SelW-1:0]   accSlave,
  input  logic [DATA_W-1:0] slvRdData,
  output logic [DATA_W-1:0] mstRdData,
  output logic              accGrant,
  output logic              nmiPulse,
  output logic              rstReqPulse
);
  cfgStrobe_t strb;
  logic lockQ, respSelQ, accDenied;

  guard_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgKey(cfgWrData[15:8]), .lockQ(lockQ), .respSelQ(respSelQ),
    .accDenied(accDenied), .strb(strb), .nmiPulse(nmiPulse),
    .rstReqPulse(rstReqPulse)
  );

  guard_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .lockQ(lockQ), .respSelQ(respSelQ),
    .accValid(accValid), .accGroupA(accGroupA), .accWrite(accWrite),
    .accSlave(accSlave), .slvRdData(slvRdData), .mstRdData(mstRdData),
    .accGrant(accGrant), .accDenied(accDenied)
  );
endmodule

// File: tb/test_slave_access_guard.sv
module test_slave_access_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = '0;
  logic [15:0] cfgWrData = '0, cfgRdData;
  logic accValid = 1'b0, accGroupA = 1'b0, accWrite = 1'b0;
  logic [2:0] accSlave = '0;
  logic [31:0] slvRdData = '0, mstRdData;
  logic accGrant, nmiPulse, rstReqPulse;

  slave_access_guard i_slave_access_guard (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit mResp = 0, mLock = 0;
  bit [3:0] mAcr [6];
  bit eNmi = 0, eRst = 0;
  logic [15:0] lastRd;
  logic lastGrant;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slotOf(input logic [7:0] a);
    for (int i = 0; i < 6; i++)
      if (a == ((i < 3) ? 8'h10 + 8'(4*i) : 8'h20 + 8'(4*(i-3)))) return i;
    return -1;
  endfunction

  function automatic logic [15:0] expRd(input logic [7:0] a);
    int s = slotOf(a);
    if (a == 8'h00) return {14'b0, mLock, mResp};
    if (s >= 0) return {12'b0, mAcr[s]};
    return 16'h0;
  endfunction

  function automatic bit expDeny(input bit ga, input bit wr, input logic [2:0] sl);
    if (sl > 3'd5) return 1'b0;
    return mAcr[sl][{ga, wr}];
  endfunction

  task automatic doCycle(input bit we, input logic [7:0] a, input logic [15:0] wd,
                         input bit av, input bit ga, input bit wr, input logic [2:0] sl,
                         input logic [31:0] sd);
    bit den;
    int s;
    @(negedge clk);
    chk(nmiPulse == eNmi, "R9 nmiPulse", nmiPulse, eNmi);
    chk(rstReqPulse == eRst, "R9 rstReqPulse", rstReqPulse, eRst);
    cfgWrEn = we; cfgAddr = a; cfgWrData = wd;
    accValid = av; accGroupA = ga; accWrite = wr; accSlave = sl; slvRdData = sd;
    #1;
    lastRd = cfgRdData;
    lastGrant = accGrant;
    chk(cfgRdData == expRd(a), "R6/R10 readback", cfgRdData, expRd(a));
    den = av && expDeny(ga, wr, sl);
    chk(accGrant == (av && !den), "R7 grant", accGrant, av && !den);
    if (av) chk(mstRdData == (den ? 32'h0 : sd), "R8 read data", mstRdData, den ? 32'h0 : sd);
    eNmi = den && !mResp;
    eRst = den && mResp;
    if (we) begin
      s = slotOf(a);
      if (a == 8'h00) begin
        if (wd[15:8] == 8'hA5) begin mLock = wd[1]; mResp = wd[0]; end
      end else if (s >= 0 && !mLock) begin
        mAcr[s] = wd[3:0] & ((s == 0) ? 4'hC : 4'hF);
      end
    end
  endtask

  task automatic cfgW(input logic [7:0] a, input logic [15:0] wd);
    doCycle(1, a, wd, 0, 0, 0, 0, 0);
  endtask
  task automatic cfgR(input logic [7:0] a);
    doCycle(0, a, 16'h0, 0, 0, 0, 0, 0);
  endtask
  task automatic acc(input bit ga, input bit wr, input logic [2:0] sl);
    doCycle(0, 8'h00, 16'h0, 1, ga, wr, sl, 32'hCAFE_0000 | 32'(sl));
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [7] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28};
    int seed = 32'h5A17;
    void'($urandom(seed));
    for (int i = 0; i < 6; i++) mAcr[i] = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    cfgR(8'h00); chk(lastRd == 16'h0, "R1 control after reset", lastRd, 0);
    cfgR(8'h28); chk(lastRd == 16'h0, "R1 slot 5 after reset", lastRd, 0);
    acc(1, 1, 3'd2); chk(lastGrant == 1'b1, "R1 granted after reset", lastGrant, 1);

    // R2: wrong key ignored, right key applies
    cfgW(8'h00, 16'h3C03); cfgR(8'h00);
    chk(lastRd == 16'h0, "R2 wrong key", lastRd, 0);
    cfgW(8'h00, 16'hA5FF); cfgR(8'h00);
    chk(lastRd == 16'h0003, "R3 control readback masks key and reserved", lastRd, 3);
    cfgW(8'h00, 16'hA500);

    // R5: field layout, slot 0 partial
    cfgW(8'h14, 16'hFFFF); cfgR(8'h14);
    chk(lastRd == 16'h000F, "R5 flash slot bits", lastRd, 16'hF);
    cfgW(8'h10, 16'hFFFF); cfgR(8'h10);
    chk(lastRd == 16'h000C, "R5 main slot bits", lastRd, 16'hC);
    acc(0, 0, 3'd0); chk(lastGrant == 1'b1, "R5 main slot CPU read open", lastGrant, 1);
    acc(1, 1, 3'd0); chk(lastGrant == 1'b0, "R7 group A write refused", lastGrant, 0);
    acc(0, 0, 3'd1);  // R9: previous refusal pulses nmi here
    // R7: slots 6 and 7 are never refused
    acc(1, 1, 3'd6); chk(lastGrant == 1'b1, "R7 slot 6 open", lastGrant, 1);

    // R4: lock freezes slots, control still keyed
    cfgW(8'h00, 16'hA502);
    cfgW(8'h18, 16'h000F); cfgR(8'h18);
    chk(lastRd == 16'h0, "R4 locked slot write ignored", lastRd, 0);
    cfgR(8'h14); chk(lastRd == 16'h000F, "R4 locked slot still readable", lastRd, 16'hF);
    cfgW(8'h00, 16'hA503); cfgR(8'h00);
    chk(lastRd == 16'h0003, "R4 control writable while locked", lastRd, 3);
    acc(0, 1, 3'd1);  // R9: reset request next cycle
    cfgW(8'h00, 16'hA500);

    // R10: unmapped offsets
    cfgW(8'h0C, 16'hFFFF); cfgR(8'h0C);
    chk(lastRd == 16'h0, "R10 unmapped read", lastRd, 0);
    cfgW(8'h1C, 16'hFFFF); cfgR(8'h18);
    chk(lastRd == 16'h0, "R10 unmapped write no effect", lastRd, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit we = $urandom_range(0, 1);
      logic [7:0] a = ($urandom_range(0, 7) == 7) ? 8'($urandom) : offs[$urandom_range(0, 6)];
      logic [15:0] wd = 16'($urandom);
      if ($urandom_range(0, 1) == 1) wd[15:8] = 8'hA5;
      doCycle(we, a, wd, 1'($urandom), 1'($urandom), 1'($urandom),
              3'($urandom), $urandom);
    end
    doCycle(0, 8'h00, 16'h0, 0, 0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule